// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block walks an external DDR3 device through its power-up reset. After a start pulse it drives the memory reset control bit to its asserted level, holds it for a fixed number of microseconds, releases it, and waits a further fixed margin before raising CKE. In the cycle CKE rises it fires a one-cycle trigger to a downstream initialisation engine. It then waits for that engine's busy flag to rise and fall again. A done flag reports success. A timeout flag reports an engine that fails to finish within the allowed window.

All delays are counted in pulses of a one-per-microsecond tick input, so they do not depend on the system clock rate. The polarity of the reset control bit is taken from a revision input that is sampled at start. Some revisions drive the bit high to assert reset, and the others drive it low. Alongside the sequence, the block builds the mode-register-0 word from the CAS latency and the memory clock in MHz. It derives the write-recovery code from the clock frequency.

All pins are plain control and status levels or pulses. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While and after reset, `mem_rst_ctl_o` is 1 and `cke_o`, `init_go_o`, `done_o` and `timeout_o` are 0.
- R2: A start accepted at clock edge A sets `mem_rst_ctl_o` to the value of `rev_hi_i` at that edge (the asserted level). It holds that level until the edge that carries the HOLD_US-th tick after A. At that edge it changes to the inverse (the released level).
- R3: The polarity works for both revision values. With `rev_hi_i`=1 the pulse is 1 then 0. With `rev_hi_i`=0 it is 0 then 1.
- R4: `cke_o` rises at the edge carrying the CKE_US-th tick after the reset release. Only ticks are counted, so the delay in clock cycles scales with the tick spacing.
- R5: `init_go_o` is high for exactly one cycle, starting at the edge where `cke_o` rises.
- R6: After the trigger, `done_o` is set at the first edge where `init_busy_i` is 0 after having been seen 1. `done_o` and `cke_o` stay high until the next start.
- R7: If completion has not occurred by the edge carrying the TMO_US-th tick after the trigger, `timeout_o` is set. This covers busy never rising and busy never falling. `timeout_o` stays set with `done_o` at 0 until the next accepted start, which clears it.
- R8: A start pulse while the sequence is running (reset hold, CKE margin, or waiting on the engine) is ignored. The outputs and the timing are unchanged.
- R9: `mr0_o` is registered one cycle after its inputs. Bits [1:0] (burst length) are 0, bits [6:4] are `cas_lat_i`-4, and every bit outside [6:4] and [11:9] is 0.
- R10: Bits [11:9] of `mr0_o` hold the write-recovery code for twr = ceil(15*MHz/1000). The code is 1 for twr<5, twr-4 for 5..8, 5 for 9..10, and 6 for twr>10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request; accepted only when not running |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| rev_hi_i | input | 1 | 1: reset control bit is active-high; 0: active-low |
| init_busy_i | input | 1 | Busy flag of the downstream initialisation engine |
| cas_lat_i | input | CAS_W | CAS latency in clocks (4..11) |
| clk_mhz_i | input | FREQ_W | Memory clock frequency in MHz |
| mem_rst_ctl_o | output | 1 | Memory reset control bit |
| cke_o | output | 1 | Memory clock enable |
| init_go_o | output | 1 | One-cycle trigger for the initialisation engine |
| done_o | output | 1 | Sequence finished successfully |
| timeout_o | output | 1 | Engine did not finish in time (sticky) |
| mr0_o | output | MR_W | Assembled mode-register-0 word |

## Verification
The hardest states to reach are the two engine failures. In one, busy never rises after the trigger. In the other, busy rises and never falls. Neither can be produced by a cooperative engine. The bench's stub engine therefore has selectable behaviours, and the timeout window is shortened by parameter so that both failures, and recovery from them on the next start, fit in a short run. Tick independence is reached by spacing the tick input three clocks apart for one whole sequence and predicting every output edge from that tick schedule.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_CKE_WAIT,
    ST_INIT_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  localparam int unsigned TWR_NS = 15;

  // Write-recovery code derived from the memory clock in MHz.
  function automatic logic [2:0] wr_code(input int unsigned mhz);
    int unsigned twr_ck;
    twr_ck = (TWR_NS * mhz + 999) / 1000;
    if (twr_ck < 5)        return 3'd1;
    else if (twr_ck <= 8)  return 3'(twr_ck - 4);
    else if (twr_ck <= 10) return 3'd5;
    else                   return 3'd6;
  endfunction

endpackage

// File: rtl/us_interval_timer.sv
module us_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && tick_i && (cnt_q == last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (en_i && tick_i) cnt_q <= expire_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mr0_encoder.sv
module mr0_encoder
  import ddr3_pwrup_pkg::*;
#(
  parameter int CAS_W  = 4,
  parameter int FREQ_W = 11,
  parameter int MR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAS_W-1:0]  cas_i,
  input  logic [FREQ_W-1:0] mhz_i,
  output logic [MR_W-1:0]   mr0_o
);
  localparam int CL_LSB = 4;
  localparam int WR_LSB = 9;

  logic [2:0]      cl_code;
  logic [2:0]      wr_val;
  logic [MR_W-1:0] word;

  assign cl_code = 3'(cas_i - CAS_W'(4));
  assign wr_val  = wr_code(32'(mhz_i));

  always_comb begin
    word                  = '0;
    word[CL_LSB +: 3]     = cl_code;
    word[WR_LSB +: 3]     = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mr0_o <= '0;
    else        mr0_o <= word;
  end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int HOLD_US = 200,
  parameter int CKE_US  = 500,
  parameter int TMO_US  = 1000000,
  parameter int CAS_W   = 4,
  parameter int FREQ_W  = 11,
  parameter int MR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              us_tick_i,
  input  logic              rev_hi_i,
  input  logic              init_busy_i,
  input  logic [CAS_W-1:0]  cas_lat_i,
  input  logic [FREQ_W-1:0] clk_mhz_i,
  output logic              mem_rst_ctl_o,
  output logic              cke_o,
  output logic              init_go_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [MR_W-1:0]   mr0_o
);
  localparam int LIM_A   = (HOLD_US > CKE_US) ? HOLD_US : CKE_US;
  localparam int LIM_MAX = (TMO_US > LIM_A) ? TMO_US : LIM_A;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_US - 1);
  localparam logic [CNT_W-1:0] CKE_LAST  = CNT_W'(CKE_US - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_US - 1);

  seq_state_e       state_q;
  logic             rev_q;
  logic             seen_q;
  logic             run_w;
  logic             pre_cke_w;
  logic             accept_w;
  logic             expire_w;
  logic [CNT_W-1:0] last_w;

  assign pre_cke_w = (state_q == ST_RST_HOLD) || (state_q == ST_CKE_WAIT);
  assign run_w     = pre_cke_w || (state_q == ST_INIT_WAIT);
  assign accept_w  = start_i && !run_w;

  always_comb begin
    case (state_q)
      ST_RST_HOLD: last_w = HOLD_LAST;
      ST_CKE_WAIT: last_w = CKE_LAST;
      default:     last_w = TMO_LAST;
    endcase
  end

  us_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (accept_w),
    .en_i     (run_w),
    .tick_i   (us_tick_i),
    .last_i   (last_w),
    .expire_o (expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      rev_q         <= 1'b0;
      seen_q        <= 1'b0;
      mem_rst_ctl_o <= 1'b1;
      cke_o         <= 1'b0;
      init_go_o     <= 1'b0;
      done_o        <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      init_go_o <= 1'b0;
      case (state_q)
        ST_RST_HOLD: begin
          if (expire_w) begin
            mem_rst_ctl_o <= ~rev_q;
            state_q       <= ST_CKE_WAIT;
          end
        end
        ST_CKE_WAIT: begin
          if (expire_w) begin
            cke_o     <= 1'b1;
            init_go_o <= 1'b1;
            state_q   <= ST_INIT_WAIT;
          end
        end
        ST_INIT_WAIT: begin
          if (init_busy_i) seen_q <= 1'b1;
          if (seen_q && !init_busy_i) begin
            done_o  <= 1'b1;
            state_q <= ST_DONE;
          end else if (expire_w) begin
            timeout_o <= 1'b1;
            state_q   <= ST_FAIL;
          end
        end
        default: begin
          if (start_i) begin
            rev_q         <= rev_hi_i;
            mem_rst_ctl_o <= rev_hi_i;
            seen_q        <= 1'b0;
            cke_o         <= 1'b0;
            done_o        <= 1'b0;
            timeout_o     <= 1'b0;
            state_q       <= ST_RST_HOLD;
          end
        end
      endcase
    end
  end

  mr0_encoder #(.CAS_W(CAS_W), .FREQ_W(FREQ_W), .MR_W(MR_W)) u_mr0 (
    .clk   (clk),
    .rst_n (rst_n),
    .cas_i (cas_lat_i),
    .mhz_i (clk_mhz_i),
    .mr0_o (mr0_o)
  );
endmodule

// File: rtl/ddr3_pwrup_chk.sv
module ddr3_pwrup_chk #(
  parameter int HOLD_US = 200,
  parameter int CKE_US  = 500
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_i,
  input logic run_i,
  input logic pre_cke_i,
  input logic cke_i,
  input logic go_i,
  input logic done_i,
  input logic tmo_i
);
  logic [31:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tick_cnt <= '0;
    else if (start_i && !run_i)  tick_cnt <= '0;
    else if (pre_cke_i && tick_i) tick_cnt <= tick_cnt + 32'd1;
  end

  // R4: CKE rises only after reset hold plus margin, counted in ticks
  p_cke_margin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_i) |-> (tick_cnt == 32'(HOLD_US + CKE_US)));

  // R4: CKE low during reset hold and margin
  p_cke_low_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cke_i |-> !cke_i);

  // R5: trigger lasts one cycle
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> !go_i);

  // R5: trigger coincides with CKE high
  p_go_with_cke_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (cke_i && !done_i && !tmo_i));

  // R6: done holds until a start
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> done_i);

  // R7: timeout holds until a start
  p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_i && !start_i) |=> tmo_i);

  // R7: done and timeout are never both set
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && tmo_i));
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_chk #(.HOLD_US(HOLD_US), .CKE_US(CKE_US)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .tick_i    (us_tick_i),
  .run_i     (run_w),
  .pre_cke_i (pre_cke_w),
  .cke_i     (cke_o),
  .go_i      (init_go_o),
  .done_i    (done_o),
  .tmo_i     (timeout_o)
);

// File: tb/tb_ddr3_pwrup_seq.sv
module tb_ddr3_pwrup_seq;
  localparam int HOLD = 200;
  localparam int CKE  = 500;
  localparam int TMO  = 60;
  localparam int M_NORM  = 0;
  localparam int M_NEVER = 1;
  localparam int M_STUCK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic rev_hi = 1'b0;
  logic busy = 1'b0;
  logic [3:0]  cas = 4'd6;
  logic [10:0] mhz = 11'd400;
  logic        rst_ctl, cke, go, done, tmo;
  logic [15:0] mr0;

  ddr3_pwrup_seq #(.HOLD_US(HOLD), .CKE_US(CKE), .TMO_US(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(tick),
    .rev_hi_i(rev_hi), .init_busy_i(busy), .cas_lat_i(cas), .clk_mhz_i(mhz),
    .mem_rst_ctl_o(rst_ctl), .cke_o(cke), .init_go_o(go), .done_o(done),
    .timeout_o(tmo), .mr0_o(mr0)
  );

  always #10 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [4:0] v;
    string      tag;
  } ev_t;

  ev_t        evq[$];
  logic [4:0] exp_prev = 5'b10000;
  int ecnt = 0;
  int tick_per = 1;
  int eng_mode = M_NORM;
  int eng_len = 5;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always @(posedge clk) ecnt = ecnt + 1;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d act=%h exp=%h", tag, ecnt, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // tick generator: tick is high at edges that are multiples of tick_per
  initial forever begin
    @(negedge clk);
    tick = (((ecnt + 1) % tick_per) == 0);
  end

  // stub initialisation engine
  initial forever begin
    @(negedge clk);
    if (go) begin
      if (eng_mode == M_NORM) begin
        busy = 1'b1;
        repeat (eng_len) @(negedge clk);
        busy = 1'b0;
      end else if (eng_mode == M_STUCK) begin
        busy = 1'b1;
      end
    end
  end

  // monitor: compares every change of the output vector with the queue
  initial begin
    logic [4:0] prev, cur;
    @(posedge rst_n);
    @(negedge clk);
    prev = {rst_ctl, cke, go, done, tmo};
    forever begin
      @(negedge clk);
      cur = {rst_ctl, cke, go, done, tmo};
      if (cur != prev) begin
        if (evq.size() == 0) begin
          check(1'b0, "R8 unexpected change", {11'd0, cur}, {11'd0, prev});
        end else begin
          ev_t e;
          e = evq.pop_front();
          check((e.cyc == ecnt) && (e.v == cur), e.tag, {11'd0, cur}, {11'd0, e.v});
          if (e.cyc != ecnt)
            $display("  expected at cycle %0d", e.cyc);
        end
      end
      prev = cur;
    end
  end

  function automatic int nth_tick(input int after, input int n);
    int e = after;
    int c = 0;
    while (c < n) begin
      e++;
      if ((e % tick_per) == 0) c++;
    end
    return e;
  endfunction

  task automatic push(input int cyc, input logic [4:0] v, input string tag);
    if (v != exp_prev) begin
      ev_t e;
      e.cyc = cyc; e.v = v; e.tag = tag;
      evq.push_back(e);
      exp_prev = v;
    end
  endtask

  // driver: launches a sequence and queues every expected output edge
  task automatic run_seq(input bit rv, input int mode, input string ptag, input bit poke);
    int a, t1, t2, last;
    @(negedge clk);
    busy = 1'b0;
    eng_mode = mode;
    rev_hi = rv;
    start = 1'b1;
    a = ecnt + 1;
    push(a, {rv, 4'b0000}, ptag);
    t1 = nth_tick(a, HOLD);
    push(t1, {~rv, 4'b0000}, ptag);
    t2 = nth_tick(t1, CKE);
    push(t2, {~rv, 4'b1100}, "R4");
    push(t2 + 1, {~rv, 4'b1000}, "R5");
    if (mode == M_NORM) begin
      last = t2 + eng_len + 1;
      push(last, {~rv, 4'b1010}, "R6");
    end else begin
      last = nth_tick(t2, TMO);
      push(last, {~rv, 4'b1001}, "R7");
    end
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: a start during reset hold, with the other polarity, is ignored
      repeat (40) @(negedge clk);
      rev_hi = ~rv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(rst_ctl == rv, "R8", {15'd0, rst_ctl}, {15'd0, rv});
    end
    while (ecnt < last + 3) @(negedge clk);
  endtask

  task automatic chk_mr0(input int c, input int f, input int exp_wr);
    logic [15:0] exp;
    @(negedge clk);
    cas = 4'(c);
    mhz = 11'(f);
    @(negedge clk);
    @(negedge clk);
    exp = (16'(exp_wr) << 9) | (16'(c - 4) << 4);
    check(mr0[6:4] == exp[6:4] && mr0[1:0] == 2'b00 && mr0[15:12] == 4'd0 && mr0[8:7] == 2'b00 && mr0[3:2] == 2'b00,
          "R9", mr0, exp);
    check(mr0[11:9] == exp[11:9], "R10", mr0, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired, pending events=%0d", evq.size());
    wrap_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check({rst_ctl, cke, go, done, tmo} == 5'b10000, "R1", {11'd0, rst_ctl, cke, go, done, tmo}, 16'h0010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({rst_ctl, cke, go, done, tmo} == 5'b10000, "R1", {11'd0, rst_ctl, cke, go, done, tmo}, 16'h0010);

    // R9 / R10: mode-register word for several frequencies
    chk_mr0(5, 200, 1);
    chk_mr0(6, 300, 1);
    chk_mr0(6, 333, 1);
    chk_mr0(6, 334, 2);
    chk_mr0(7, 466, 3);
    chk_mr0(8, 533, 4);
    chk_mr0(9, 600, 5);
    chk_mr0(10, 640, 5);
    chk_mr0(11, 667, 6);
    chk_mr0(11, 800, 6);

    // R2: active-high revision, normal completion
    tick_per = 1;
    run_seq(1'b1, M_NORM, "R2", 1'b0);
    repeat (20) @(negedge clk);
    check(done && cke && !tmo, "R6", {13'd0, done, cke, tmo}, 16'h0006);

    // R3: active-low revision, with an ignored start (R8)
    run_seq(1'b0, M_NORM, "R3", 1'b1);

    // R4: ticks spaced three clocks apart
    tick_per = 3;
    run_seq(1'b1, M_NORM, "R4", 1'b0);
    tick_per = 1;

    // R7: engine never raises busy
    run_seq(1'b0, M_NEVER, "R3", 1'b0);
    repeat (20) @(negedge clk);
    check(tmo && !done, "R7", {14'd0, tmo, done}, 16'h0002);

    // R7: engine raises busy and never drops it
    run_seq(1'b1, M_STUCK, "R2", 1'b0);
    repeat (20) @(negedge clk);
    check(tmo && !done, "R7", {14'd0, tmo, done}, 16'h0002);

    // R7: next start clears the timeout, normal completion follows
    run_seq(1'b0, M_NORM, "R7", 1'b0);

    check(evq.size() == 0, "R8 queue drained", 16'(evq.size()), 16'd0);
    wrap_up();
  end
endmodule